// File: doc/BRIEF.md
# Four-Register Bus Processor

This block is a small multicycle execution engine. It holds four general registers, an operand latch and a result latch, and all of them exchange data over one shared internal bus. A 6-bit instruction word is presented with a start strobe. The block captures that word and steps through the control sequence for the selected operation. It raises a completion flag in the final step of each instruction. The bus value is visible at a port in every cycle. That port is also how register contents can be read out: a move of a register onto itself places its value on the bus.

Control comes from a 2-bit step counter whose value is decoded into one-hot time steps. The instruction fields are each decoded into one-hot selects. The control signals for each step are simple products of these two decoded sets. Load and register move finish one step after acceptance. Addition and subtraction go through the operand latch and the result latch, so they take three steps. The bus is built from AND-OR multiplexing, so no tri-state logic is used.

Top module: `simproc_core`

## Requirements
- R1: A synchronous active-low reset clears all four registers, the operand and result latches and the instruction latch, and returns control to step T0. After reset `done` is 0 and `bus_out` is 0.
- R2: The instruction word is split as follows. Bits [5:4] are the operation: 00 load, 01 move, 10 add, 11 subtract. Bits [3:2] select the destination register Rx. Bits [1:0] select the source register Ry.
- R3: `start` is accepted only in step T0, and the instruction word is captured at that same edge. While an instruction is in progress, changes on `start` and `instr` have no effect on the instruction being executed.
- R4: Load places `ext_data` on the bus in T1, writes the bus into Rx, and raises `done` in T1, one cycle after acceptance.
- R5: Move places Ry on the bus in T1, writes it into Rx, and raises `done` in T1. `ext_data` has no effect on a move.
- R6: Add takes three steps. In T1, Rx is placed on the bus and loaded into the operand latch. In T2, Ry is placed on the bus and the sum is loaded into the result latch. In T3, the result is placed on the bus, written into Rx, and `done` is raised. The sum wraps modulo 2^DW, and Rx and Ry may be the same register.
- R7: Subtract follows the same three steps as add and computes Rx minus Ry modulo 2^DW. Subtracting a register from itself gives 0.
- R8: When no source drives the bus, `bus_out` is 0 and `done` is 0. At most one source drives the bus in any cycle.
- R9: In the cycle after `done`, control is back in T0. A new instruction can be accepted in that T0 cycle if `start` is held high.
- R10: A reset asserted in the middle of an instruction abandons it. No `done` is raised for that instruction, and all registers read back as 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe, sampled in T0 |
| instr | input | 6 | Instruction word: operation, Rx, Ry |
| ext_data | input | DW | External data for the load operation |
| done | output | 1 | High in the final step of an instruction |
| bus_out | output | DW | Current value of the shared bus |

## Verification
The main function is tried with loads of distinct values, a move with a misleading `ext_data`, an add that overflows, a subtract that underflows, and add and subtract with the same register as both operands. Between them these separate the source select from the destination select, the add path from the subtract path, and wrapping from saturation. A scoreboard compares the bus value in every `done` cycle, along with the step latency, against a register model kept in the bench. This tells one-step operations apart from three-step ones. A test that holds `start` high while changing `instr` during an add, and then chains a move right after `done`, shows that the captured instruction is held and that T0 comes back at once. A reset placed at T2 shows that an unfinished instruction is abandoned.

// File: rtl/simproc_pkg.sv
// Package: shared widths and the operation encoding for the bus processor.
// Assumes the 6-bit instruction layout {op[1:0], rx[1:0], ry[1:0]}.
package simproc_pkg;
    localparam int OP_W    = 2;
    localparam int RSEL_W  = 2;
    localparam int INSTR_W = OP_W + 2 * RSEL_W;
    localparam int NREG    = 1 << RSEL_W;
    localparam int NSTEP   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 2'b00,
        OP_MOVE = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } op_e;
endpackage

// File: rtl/simproc_dec.sv
// Binary-to-one-hot decoder, always enabled.
// Assumes IW is small (output width is 2**IW).
module simproc_dec #(
    parameter int IW = 2
) (
    input  logic [IW-1:0]      sel,
    output logic [(1<<IW)-1:0] onehot
);
    localparam int OW = 1 << IW;

    // Raise exactly the output selected by the binary code.
    always_comb begin
        onehot      = '0;
        onehot[sel] = 1'b1;
    end

    logic unused_ow;
    assign unused_ow = (OW == 0);
endmodule

// File: rtl/simproc_ctrl.sv
// Control path: step counter plus decoder, instruction latch plus field decoders,
// and the per-step control signals that drive the datapath.
// Assumes a synchronous active-low reset and that start is sampled only in T0.
module simproc_ctrl
    import simproc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic               done,
    output logic               ext_sel,
    output logic [NREG-1:0]    reg_out,
    output logic [NREG-1:0]    reg_in,
    output logic               a_in,
    output logic               g_in,
    output logic               g_out,
    output logic               sub_mode
);
    logic [1:0]         step_q;
    logic [NSTEP-1:0]   t_oh;
    logic [INSTR_W-1:0] func_q;
    logic [3:0]         i_oh;
    logic [NREG-1:0]    x_oh;
    logic [NREG-1:0]    y_oh;
    logic               accept;
    logic               busy;
    logic               arith;

    simproc_dec #(.IW(2))      u_step_dec (.sel(step_q),                       .onehot(t_oh));
    simproc_dec #(.IW(OP_W))   u_op_dec   (.sel(func_q[INSTR_W-1 -: OP_W]),    .onehot(i_oh));
    simproc_dec #(.IW(RSEL_W)) u_rx_dec   (.sel(func_q[2*RSEL_W-1 -: RSEL_W]), .onehot(x_oh));
    simproc_dec #(.IW(RSEL_W)) u_ry_dec   (.sel(func_q[RSEL_W-1:0]),           .onehot(y_oh));

    assign accept = t_oh[0] & start;
    assign busy   = ~t_oh[0];
    assign arith  = i_oh[OP_ADD] | i_oh[OP_SUB];

    // Step counter: clear on reset or completion, advance while an instruction runs.
    always_ff @(posedge clk) begin
        if (!rst_n || done)
            step_q <= '0;
        else if (accept || busy)
            step_q <= step_q + 2'd1;
    end

    // Instruction latch: capture the word only when start is accepted in T0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            func_q <= '0;
        else if (accept)
            func_q <= instr;
    end

    // Per-step control products of the decoded step and decoded fields.
    always_comb begin
        done     = ((i_oh[OP_LOAD] | i_oh[OP_MOVE]) & t_oh[1]) | (arith & t_oh[3]);
        ext_sel  = i_oh[OP_LOAD] & t_oh[1];
        a_in     = arith & t_oh[1];
        g_in     = arith & t_oh[2];
        g_out    = arith & t_oh[3];
        sub_mode = i_oh[OP_SUB];
        reg_in   = done ? x_oh : '0;
        reg_out  = '0;
        if ((i_oh[OP_MOVE] & t_oh[1]) | (arith & t_oh[2]))
            reg_out = y_oh;
        else if (arith & t_oh[1])
            reg_out = x_oh;
    end

    AST_LOAD_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> $past(accept)) else $error("load data on bus without prior accept"); // R4
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> t_oh[0]) else $error("control not back in T0 after done"); // R9
    AST_BUSY_HOLDS_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(func_q)) else $error("instruction latch changed while busy"); // R3
endmodule

// File: rtl/simproc_datapath.sv
// Datapath: four general registers, operand latch A, result latch G,
// an add/subtract unit and an AND-OR multiplexed shared bus.
// Assumes the control path never selects more than one bus source at a time.
module simproc_datapath
    import simproc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   ext_data,
    input  logic            ext_sel,
    input  logic [NREG-1:0] reg_out,
    input  logic [NREG-1:0] reg_in,
    input  logic            a_in,
    input  logic            g_in,
    input  logic            g_out,
    input  logic            sub_mode,
    output logic [DW-1:0]   bus
);
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] a_q;
    logic [DW-1:0] g_q;
    logic [DW-1:0] alu_res;

    // Bus multiplexer: OR of every source gated by its select; zero when idle.
    always_comb begin
        bus = ({DW{ext_sel}} & ext_data) | ({DW{g_out}} & g_q);
        for (int k = 0; k < NREG; k++)
            bus = bus | ({DW{reg_out[k]}} & regs[k]);
    end

    // Add/subtract unit on operand latch and bus.
    assign alu_res = sub_mode ? (a_q - bus) : (a_q + bus);

    // General registers: each loads the bus when its write select is high.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (!rst_n)
                regs[k] <= '0;
            else if (reg_in[k])
                regs[k] <= bus;
        end
    end

    // Operand and result latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            g_q <= '0;
        end else begin
            if (a_in) a_q <= bus;
            if (g_in) g_q <= alu_res;
        end
    end

    AST_ONE_BUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_sel, g_out, reg_out})) else $error("bus has several drivers"); // R8
    AST_G_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        g_out |-> $past(g_in)) else $error("result driven before it was computed"); // R6
endmodule

// File: rtl/simproc_core.sv
// Top of the four-register bus processor: ties the control path to the datapath.
// Assumes synchronous active-low reset; bus_out shows the shared bus every cycle.
module simproc_core
    import simproc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DW-1:0]      ext_data,
    output logic               done,
    output logic [DW-1:0]      bus_out
);
    logic            ext_sel;
    logic [NREG-1:0] reg_out;
    logic [NREG-1:0] reg_in;
    logic            a_in;
    logic            g_in;
    logic            g_out;
    logic            sub_mode;

    simproc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .done(done), .ext_sel(ext_sel), .reg_out(reg_out), .reg_in(reg_in),
        .a_in(a_in), .g_in(g_in), .g_out(g_out), .sub_mode(sub_mode)
    );

    simproc_datapath #(.DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .ext_data(ext_data), .ext_sel(ext_sel),
        .reg_out(reg_out), .reg_in(reg_in), .a_in(a_in), .g_in(g_in),
        .g_out(g_out), .sub_mode(sub_mode), .bus(bus_out)
    );
endmodule

// File: tb/tb_simproc_core.sv
// Scoreboard bench: the driver pushes expected bus value and latency per
// instruction, and the monitor pops and compares them in every done cycle.
module tb_simproc_core;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [5:0]    instr = '0;
    logic [DW-1:0] ext_data = '0;
    logic          done;
    logic [DW-1:0] bus_out;

    typedef struct {
        logic [DW-1:0] data;
        int            lat;
        int            issued;
        string         tag;
    } item_t;

    item_t         sbq[$];
    logic [DW-1:0] model [4];
    int            cyc = 0;
    int            total = 0;
    int            bad = 0;
    bit            finished = 1'b0;

    simproc_core #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .ext_data(ext_data), .done(done), .bus_out(bus_out)
    );

    always #2.5 clk = ~clk;

    // Cycle counter.
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare bus value and latency in each done cycle.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                chk(bus_out == it.data, it.tag, bus_out, it.data);
                chk((cyc - it.issued) == it.lat, {it.tag, " latency"}, cyc - it.issued, it.lat);
            end
        end
    end

    function automatic logic [5:0] enc(input int op, input int rx, input int ry);
        return {op[1:0], rx[1:0], ry[1:0]};
    endfunction

    // Compute expected value from the bench's register model.
    function automatic logic [DW-1:0] predict(input int op, input int rx, input int ry,
                                              input logic [DW-1:0] d);
        case (op)
            0: return d;
            1: return model[ry];
            2: return model[rx] + model[ry];
            default: return model[rx] - model[ry];
        endcase
    endfunction

    // Driver: issue one instruction, push its expectation, wait for completion.
    task automatic issue(input int op, input int rx, input int ry,
                         input logic [DW-1:0] d, input string tag);
        item_t it;
        @(negedge clk);
        instr    = enc(op, rx, ry);
        ext_data = d;
        start    = 1'b1;
        it.data   = predict(op, rx, ry, d);
        it.lat    = (op < 2) ? 1 : 3;
        it.issued = cyc;
        it.tag    = tag;
        model[rx] = it.data;
        sbq.push_back(it);
        @(negedge clk);
        start = 1'b0;
        wait (sbq.size() == 0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(bus_out == '0, "R1 bus after reset", bus_out, 0);

        issue(0, 0, 0, 8'h15, "R4 load R0");
        @(negedge clk);
        instr = 6'h08; ext_data = 8'h03; start = 1'b1;       // R2 example code: load R2
        begin
            item_t it;
            it.data = 8'h03; it.lat = 1; it.issued = cyc; it.tag = "R2 load R2 code 08";
            model[2] = 8'h03; sbq.push_back(it);
        end
        @(negedge clk); start = 1'b0; wait (sbq.size() == 0);
        issue(0, 1, 0, 8'hFF, "R4 load R1");
        issue(0, 3, 0, 8'h40, "R4 load R3");
        issue(1, 3, 0, 8'hAA, "R5 move R3,R0 (code 1C) ext ignored");
        issue(2, 1, 3, 8'h00, "R6 add R1,R3 (code 27) wrap");
        issue(3, 0, 2, 8'h00, "R7 sub R0,R2 (code 32)");
        issue(3, 2, 3, 8'h55, "R7 sub R2,R3 underflow");
        issue(2, 3, 3, 8'h00, "R6 add R3,R3 same reg");
        issue(3, 1, 1, 8'h00, "R7 sub R1,R1 zero");
        issue(1, 0, 0, 8'h00, "R5 probe R0");
        issue(1, 2, 2, 8'h00, "R5 probe R2");

        @(negedge clk);
        chk(bus_out == '0, "R8 idle bus", bus_out, 0);
        chk(done == 1'b0, "R8 idle done", done, 0);

        // R3 and R9: start held high, instr changed mid-add, chained move.
        begin
            item_t it;
            @(negedge clk);
            instr = enc(2, 2, 3); ext_data = 8'h00; start = 1'b1;
            it.data = model[2] + model[3]; it.lat = 3; it.issued = cyc;
            it.tag = "R3 add R2,R3 with busy start/instr";
            model[2] = it.data; sbq.push_back(it);
            @(negedge clk);
            instr = enc(0, 2, 0); ext_data = 8'h77;           // must be ignored
            while (!done) @(negedge clk);
            instr = enc(1, 0, 2);
            @(negedge clk);                                    // T0 with start high
            it.data = model[2]; it.lat = 1; it.issued = cyc;
            it.tag = "R9 chained move R0,R2";
            model[0] = it.data; sbq.push_back(it);
            @(negedge clk);
            start = 1'b0;
            wait (sbq.size() == 0);
        end

        // R10: reset in T2 of an add abandons it.
        @(negedge clk);
        instr = enc(2, 0, 3); start = 1'b1;
        @(negedge clk); start = 1'b0;                          // T1
        @(negedge clk);                                        // T2
        chk(done == 1'b0, "R10 no done in T2", done, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10 done during reset", done, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) model[k] = '0;
        @(negedge clk);
        chk(bus_out == '0, "R10 bus after abort", bus_out, 0);
        issue(1, 0, 0, 8'h00, "R10 probe R0 cleared");
        issue(1, 3, 3, 8'h00, "R1 probe R3 cleared");
        issue(1, 2, 2, 8'h00, "R1 probe R2 cleared");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R8 pending items", sbq.size(), 0);
        report();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        report();
    end
endmodule